// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block runs a complete block erase on an 8-bit parallel NAND flash bus on behalf of a host-side user. The user gives a one-cycle start pulse together with a row address. The sequencer then drives chip enable and the latch and strobe lines. It sends the erase setup command, the row address cycles and the erase confirm command. It waits for the device's ready/busy line to come back high, reads the status byte and reports pass or fail.

The row address is made of a page field in its low bits and a block field above it. An erase acts on a whole block, so the page field is forced to zero before the address cycles go out. A guard delay follows the confirm strobe and the controller does not look at ready/busy until that delay has passed. If ready/busy stays low past a programmable limit, the operation ends with a timeout flag and skips the status read. All bus strobes come straight from registers, and every width and timing count is a parameter.

Top module: `nand_erase_seq`

## Requirements
- R1: While reset is held and after it is released, nand_ce_n_o, nand_we_n_o and nand_re_n_o are 1, nand_cle_o and nand_ale_o are 0, and busy_o and done_o are 0.
- R2: After a start pulse, the first write strobe carries command byte 0x60 with nand_cle_o=1 and nand_ale_o=0. No cycle ever has both latch lines high.
- R3: The next ADDR_CYC write strobes (three by default) are address cycles with nand_ale_o=1 and nand_cle_o=0. They carry the row address least significant byte first, with the low PAGE_W bits (the page field) forced to 0 whatever their input value.
- R4: The strobe after the address cycles carries command 0xD0 with nand_cle_o=1.
- R5: Every write strobe holds nand_we_n_o low for at least TWP cycles. Successive strobes within one operation are separated by at least TWH high cycles. nand_dq_o, nand_cle_o and nand_ale_o do not change while nand_we_n_o is low.
- R6: After the confirm strobe, the controller waits TWB cycles before it samples ready/busy. The status command 0x70 goes out only after nand_rb_i has returned high.
- R7: After 0x70, nand_re_n_o goes low for TREA cycles and never overlaps a write strobe. fail_o takes bit 0 of the status byte (1 means the erase failed). done_o pulses for one cycle.
- R8: busy_o is 1 from the cycle after start until done_o, and nand_ce_n_o is 0 for as long as busy_o is 1. done_o coincides with busy_o falling.
- R9: A start pulse that arrives while busy_o is 1 is ignored: the bus sequence of the running operation is unchanged and no extra sequence follows.
- R10: If ready/busy stays low for TOUT cycles after the guard delay, done_o pulses with timeout_o=1 and fail_o=1, and no status command is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin an erase |
| addr_i | input | PAGE_W+BLK_W | Row address; the page field in the low PAGE_W bits is ignored |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse at the end of an operation |
| fail_o | output | 1 | Result of the last operation, 1 = failed or timed out |
| timeout_o | output | 1 | Last operation ended because ready/busy stayed low too long |
| nand_ce_n_o | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_n_o | output | 1 | Write strobe, active low |
| nand_re_n_o | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe_o | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb_i | input | 1 | Ready/busy from the device, low while busy |

## Verification
The bench drives row addresses with non-zero page bits. A sequencer that leaked the page field into the address cycles would put wrong bytes on the bus, and the scoreboard reports them. The ready/busy stub pulls the line low only a couple of cycles after the confirm strobe. A design that skipped the guard delay would still see ready high and send 0x70 before the erase had even begun. The status stub drives the opposite value of bit 0 whenever the read strobe is high, so sampling at the wrong time inverts the result. A second start during an operation and a ready/busy line that never comes back test that the sequencer neither restarts nor hangs. They also check that no status read is attempted after a timeout.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;

  localparam logic [7:0] CMD_ERASE_SETUP   = 8'h60;
  localparam logic [7:0] CMD_ERASE_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_READ_STATUS   = 8'h70;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ADDR,
    ST_CONFIRM,
    ST_WAIT,
    ST_STCMD,
    ST_STREAD
  } erase_state_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_HIGH
  } wr_phase_t;

  typedef enum logic [1:0] {
    RW_IDLE,
    RW_GUARD,
    RW_POLL
  } rb_phase_t;

endpackage

// File: rtl/nand_wr_cycle.sv
module nand_wr_cycle
  import nand_erase_pkg::*;
#(
  parameter int TWP = 3,
  parameter int TWH = 2,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  logic          is_cmd_i,
  input  logic [DW-1:0] data_i,
  output logic          we_n_o,
  output logic          cle_o,
  output logic          ale_o,
  output logic [DW-1:0] dq_o,
  output logic          oe_o,
  output logic          done_o
);

  localparam int MAXW = (TWP > TWH) ? TWP : TWH;
  localparam int CW   = $clog2(MAXW + 1);

  wr_phase_t     ph;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      we_n_o <= 1'b1;
      cle_o  <= 1'b0;
      ale_o  <= 1'b0;
      dq_o   <= '0;
      oe_o   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (ph)
        PH_IDLE: begin
          if (go_i) begin
            cle_o  <= is_cmd_i;
            ale_o  <= !is_cmd_i;
            dq_o   <= data_i;
            oe_o   <= 1'b1;
            we_n_o <= 1'b0;
            cnt    <= CW'(TWP - 1);
            ph     <= PH_LOW;
          end
        end
        PH_LOW: begin
          if (cnt == '0) begin
            we_n_o <= 1'b1;
            cnt    <= CW'(TWH - 1);
            ph     <= PH_HIGH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt == '0) begin
            cle_o  <= 1'b0;
            ale_o  <= 1'b0;
            oe_o   <= 1'b0;
            done_o <= 1'b1;
            ph     <= PH_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_rb_wait.sv
module nand_rb_wait
  import nand_erase_pkg::*;
#(
  parameter int TWB  = 8,
  parameter int TOUT = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic rb_i,
  output logic ready_o,
  output logic tout_o
);

  localparam int GW = $clog2(TWB + 1);
  localparam int TW = $clog2(TOUT + 1);

  rb_phase_t     ph;
  logic [GW-1:0] gcnt;
  logic [TW-1:0] tcnt;
  logic [1:0]    rb_sync;

  always_ff @(posedge clk) begin
    if (rst) rb_sync <= 2'b11;
    else     rb_sync <= {rb_sync[0], rb_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= RW_IDLE;
      gcnt    <= '0;
      tcnt    <= '0;
      ready_o <= 1'b0;
      tout_o  <= 1'b0;
    end else begin
      ready_o <= 1'b0;
      tout_o  <= 1'b0;
      unique case (ph)
        RW_IDLE: begin
          if (go_i) begin
            gcnt <= GW'(TWB - 1);
            ph   <= RW_GUARD;
          end
        end
        RW_GUARD: begin
          if (gcnt == '0) begin
            tcnt <= '0;
            ph   <= RW_POLL;
          end else begin
            gcnt <= gcnt - 1'b1;
          end
        end
        RW_POLL: begin
          if (rb_sync[1]) begin
            ready_o <= 1'b1;
            ph      <= RW_IDLE;
          end else if (tcnt == TW'(TOUT - 1)) begin
            tout_o <= 1'b1;
            ph     <= RW_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: ph <= RW_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nand_erase_pkg::*;
#(
  parameter int         PAGE_W    = 5,
  parameter int         BLK_W     = 12,
  parameter int         ADDR_CYC  = 3,
  parameter int         TWP       = 3,
  parameter int         TWH       = 2,
  parameter int         TWB       = 8,
  parameter int         TREA      = 2,
  parameter int         TOUT      = 50000,
  parameter logic [7:0] FAIL_MASK = 8'h01
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [PAGE_W+BLK_W-1:0] addr_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    fail_o,
  output logic                    timeout_o,
  output logic                    nand_ce_n_o,
  output logic                    nand_cle_o,
  output logic                    nand_ale_o,
  output logic                    nand_we_n_o,
  output logic                    nand_re_n_o,
  output logic [7:0]              nand_dq_o,
  output logic                    nand_dq_oe_o,
  input  logic [7:0]              nand_dq_i,
  input  logic                    nand_rb_i
);

  localparam int ROW_W = PAGE_W + BLK_W;
  localparam int BUS_W = 8 * ADDR_CYC;
  localparam int AC_W  = $clog2(ADDR_CYC + 1);
  localparam int RC_W  = $clog2(TREA + 1);
  localparam logic [BUS_W-1:0] PAGE_MASK = ~(BUS_W'((1 << PAGE_W) - 1));

  erase_state_t     st;
  logic [BUS_W-1:0] row_q;
  logic [BUS_W-1:0] row_in;
  logic [AC_W-1:0]  acnt;
  logic [RC_W-1:0]  rcnt;
  logic             cyc_go;
  logic             cyc_cmd;
  logic [7:0]       cyc_data;
  logic             cyc_done;
  logic             wait_go;
  logic             rb_ready;
  logic             rb_tout;

  always_comb begin
    row_in = BUS_W'(addr_i) & PAGE_MASK;
  end

  nand_wr_cycle #(
    .TWP(TWP),
    .TWH(TWH),
    .DW (8)
  ) u_wr_cycle (
    .clk     (clk),
    .rst     (rst),
    .go_i    (cyc_go),
    .is_cmd_i(cyc_cmd),
    .data_i  (cyc_data),
    .we_n_o  (nand_we_n_o),
    .cle_o   (nand_cle_o),
    .ale_o   (nand_ale_o),
    .dq_o    (nand_dq_o),
    .oe_o    (nand_dq_oe_o),
    .done_o  (cyc_done)
  );

  nand_rb_wait #(
    .TWB (TWB),
    .TOUT(TOUT)
  ) u_rb_wait (
    .clk    (clk),
    .rst    (rst),
    .go_i   (wait_go),
    .rb_i   (nand_rb_i),
    .ready_o(rb_ready),
    .tout_o (rb_tout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      row_q       <= '0;
      acnt        <= '0;
      rcnt        <= '0;
      cyc_go      <= 1'b0;
      cyc_cmd     <= 1'b0;
      cyc_data    <= '0;
      wait_go     <= 1'b0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      fail_o      <= 1'b0;
      timeout_o   <= 1'b0;
      nand_ce_n_o <= 1'b1;
      nand_re_n_o <= 1'b1;
    end else begin
      cyc_go  <= 1'b0;
      wait_go <= 1'b0;
      done_o  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start_i) begin
            busy_o      <= 1'b1;
            nand_ce_n_o <= 1'b0;
            fail_o      <= 1'b0;
            timeout_o   <= 1'b0;
            row_q       <= row_in;
            cyc_go      <= 1'b1;
            cyc_cmd     <= 1'b1;
            cyc_data    <= CMD_ERASE_SETUP;
            st          <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cyc_done) begin
            cyc_go   <= 1'b1;
            cyc_cmd  <= 1'b0;
            cyc_data <= row_q[7:0];
            row_q    <= row_q >> 8;
            acnt     <= AC_W'(ADDR_CYC - 1);
            st       <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (cyc_done) begin
            cyc_go <= 1'b1;
            if (acnt == '0) begin
              cyc_cmd  <= 1'b1;
              cyc_data <= CMD_ERASE_CONFIRM;
              st       <= ST_CONFIRM;
            end else begin
              cyc_cmd  <= 1'b0;
              cyc_data <= row_q[7:0];
              row_q    <= row_q >> 8;
              acnt     <= acnt - 1'b1;
            end
          end
        end
        ST_CONFIRM: begin
          if (cyc_done) begin
            wait_go <= 1'b1;
            st      <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rb_tout) begin
            fail_o      <= 1'b1;
            timeout_o   <= 1'b1;
            done_o      <= 1'b1;
            busy_o      <= 1'b0;
            nand_ce_n_o <= 1'b1;
            st          <= ST_IDLE;
          end else if (rb_ready) begin
            cyc_go   <= 1'b1;
            cyc_cmd  <= 1'b1;
            cyc_data <= CMD_READ_STATUS;
            st       <= ST_STCMD;
          end
        end
        ST_STCMD: begin
          if (cyc_done) begin
            nand_re_n_o <= 1'b0;
            rcnt        <= RC_W'(TREA - 1);
            st          <= ST_STREAD;
          end
        end
        ST_STREAD: begin
          if (rcnt == '0) begin
            nand_re_n_o <= 1'b1;
            fail_o      <= |(nand_dq_i & FAIL_MASK);
            done_o      <= 1'b1;
            busy_o      <= 1'b0;
            nand_ce_n_o <= 1'b1;
            st          <= ST_IDLE;
          end else begin
            rcnt <= rcnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_erase_chk.sv
module nand_erase_chk #(
  parameter int TWP = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       busy_o,
  input logic       done_o,
  input logic       fail_o,
  input logic       timeout_o,
  input logic       nand_ce_n_o,
  input logic       nand_cle_o,
  input logic       nand_ale_o,
  input logic       nand_we_n_o,
  input logic       nand_re_n_o,
  input logic [7:0] nand_dq_o
);

  logic [15:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) low_cnt <= '0;
    else if (!nand_we_n_o) low_cnt <= (low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 1'b1;
    else low_cnt <= '0;
  end

  // R5
  we_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nand_we_n_o) |-> (low_cnt >= 16'(TWP)));

  // R5
  dq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n_o && $past(!nand_we_n_o)) |->
      ($stable(nand_dq_o) && $stable(nand_cle_o) && $stable(nand_ale_o)));

  // R2
  latch_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle_o && nand_ale_o));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n_o && !nand_re_n_o));

  // R8
  ce_active_chk: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n_o || !nand_re_n_o) |-> (!nand_ce_n_o && busy_o));

  // R8
  done_drop_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  // R10
  tout_fail_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> fail_o);

endmodule

bind nand_erase_seq nand_erase_chk #(.TWP(TWP)) u_nand_erase_chk (
  .clk        (clk),
  .rst        (rst),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .fail_o     (fail_o),
  .timeout_o  (timeout_o),
  .nand_ce_n_o(nand_ce_n_o),
  .nand_cle_o (nand_cle_o),
  .nand_ale_o (nand_ale_o),
  .nand_we_n_o(nand_we_n_o),
  .nand_re_n_o(nand_re_n_o),
  .nand_dq_o  (nand_dq_o)
);

// File: tb/test_nand_erase_seq.sv
`timescale 1ns/1ps
module test_nand_erase_seq;

  localparam int PAGE_W = 5, BLK_W = 12, ADDR_CYC = 3;
  localparam int TWP = 3, TWH = 2, TWB = 8, TREA = 2, TOUT = 60;
  localparam int ERASE_CYC = 25;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [PAGE_W+BLK_W-1:0] addr = '0;
  logic busy, done, fail, tout, ce_n, cle, ale, we_n, re_n, oe;
  logic [7:0] dq, dq_in;
  logic rb = 1'b1;
  logic [7:0] stat_byte = 8'h00;
  bit hang = 1'b0, armed = 1'b0, finished = 1'b0;
  int errors = 0, checks = 0;

  typedef struct packed { logic cle; logic ale; logic [7:0] dat; } bus_item_t;
  bus_item_t exp_q[$];

  always #5 clk = ~clk;

  assign dq_in = !re_n ? stat_byte : {7'h7F, ~stat_byte[0]};

  nand_erase_seq #(
    .PAGE_W(PAGE_W), .BLK_W(BLK_W), .ADDR_CYC(ADDR_CYC), .TWP(TWP), .TWH(TWH),
    .TWB(TWB), .TREA(TREA), .TOUT(TOUT), .FAIL_MASK(8'h01)
  ) i_nand_erase_seq (
    .clk(clk), .rst(rst), .start_i(start), .addr_i(addr),
    .busy_o(busy), .done_o(done), .fail_o(fail), .timeout_o(tout),
    .nand_ce_n_o(ce_n), .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_n_o(we_n),
    .nand_re_n_o(re_n), .nand_dq_o(dq), .nand_dq_oe_o(oe), .nand_dq_i(dq_in),
    .nand_rb_i(rb)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: every write strobe rising edge is compared with the queue
  initial begin
    wait (armed);
    forever begin
      @(posedge we_n);
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected write strobe", {22'd0, cle, ale, dq}, 32'd0);
      end else begin
        bus_item_t e;
        e = exp_q.pop_front();
        check({cle, ale, dq} === {e.cle, e.ale, e.dat}, "R2/R3/R4",
              "bus cycle {cle,ale,dq}", {22'd0, cle, ale, dq}, {22'd0, e.cle, e.ale, e.dat});
        if (e.cle && e.dat == 8'h70)
          check(rb === 1'b1, "R6", "status command while ready/busy low", rb, 1);
      end
    end
  end

  // Ready/busy stub
  initial begin
    forever begin
      @(posedge we_n);
      if (armed && cle === 1'b1 && dq == 8'hD0) begin
        repeat (2) @(negedge clk);
        rb = 1'b0;
        if (hang) wait (!hang);
        else repeat (ERASE_CYC) @(negedge clk);
        @(negedge clk);
        rb = 1'b1;
      end
    end
  end

  // Strobe width and hold sampler (R5)
  int lowc = 0, highc = 0;
  bit seen_rise = 1'b0, prev_we = 1'b1;
  logic [9:0] pbus;
  always @(negedge clk) begin
    if (armed) begin
      if (!we_n) begin
        if (prev_we && seen_rise)
          check(highc >= TWH, "R5", "write strobe high time", highc, TWH);
        if (!prev_we && pbus !== {cle, ale, dq})
          check(1'b0, "R5", "bus moved during strobe", {22'd0, cle, ale, dq}, {22'd0, pbus});
        lowc++;
        highc = 0;
      end else begin
        if (!prev_we) begin
          check(lowc >= TWP, "R5", "write strobe low time", lowc, TWP);
          seen_rise = 1'b1;
        end
        lowc = 0;
        highc++;
      end
      if (!busy) seen_rise = 1'b0;
      prev_we = we_n;
      pbus = {cle, ale, dq};
    end
  end

  task automatic run_erase(input logic [PAGE_W+BLK_W-1:0] a, input logic [7:0] st,
                           input bit hang_i, input bit poke, input string tag);
    logic [23:0] row;
    bit busy_ok = 1'b1;
    bit got_done = 1'b0;
    logic exp_fail;
    row = '0;
    row[PAGE_W+BLK_W-1:PAGE_W] = a[PAGE_W+BLK_W-1:PAGE_W];
    exp_fail = hang_i ? 1'b1 : st[0];
    exp_q.push_back({1'b1, 1'b0, 8'h60});
    for (int i = 0; i < ADDR_CYC; i++) exp_q.push_back({1'b0, 1'b1, row[8*i +: 8]});
    exp_q.push_back({1'b1, 1'b0, 8'hD0});
    if (!hang_i) exp_q.push_back({1'b1, 1'b0, 8'h70});
    stat_byte = st;
    hang = hang_i;
    @(negedge clk);
    addr = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 1; n < 5000; n++) begin
      if (done) begin got_done = 1'b1; break; end
      if (!busy || ce_n) busy_ok = 1'b0;
      if (poke && n == 6) begin start = 1'b1; addr = ~a; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(got_done, "R7", {tag, ": done pulse seen"}, got_done, 1);
    check(fail === exp_fail, hang_i ? "R10" : "R7", {tag, ": fail_o"}, fail, exp_fail);
    check(tout === hang_i, "R10", {tag, ": timeout_o"}, tout, hang_i);
    check(busy_ok, "R8", {tag, ": busy_o and chip enable held during operation"}, busy_ok, 1);
    check(busy === 1'b0 && ce_n === 1'b1, "R8", {tag, ": idle at done"}, {busy, ce_n}, 2'b01);
    if (hang_i) begin
      hang = 1'b0;
      wait (rb === 1'b1);
    end
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, hang_i ? "R10" : "R6", {tag, ": pending bus cycles"}, exp_q.size(), 0);
    exp_q.delete();
    check(done === 1'b0 && busy === 1'b0, "R9", {tag, ": no restart afterwards"}, {done, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while reset is held
    check({ce_n, we_n, re_n, cle, ale, busy, done} === 7'b1110000, "R1", "outputs in reset",
          {ce_n, we_n, re_n, cle, ale, busy, done}, 7'b1110000);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check({ce_n, we_n, re_n, cle, ale, busy, done} === 7'b1110000, "R1", "outputs after reset",
          {ce_n, we_n, re_n, cle, ale, busy, done}, 7'b1110000);
    armed = 1'b1;

    run_erase(17'h1ABC0, 8'hC0, 1'b0, 1'b0, "R3 pass, page bits zero");
    run_erase(17'h1ABDF, 8'hE0, 1'b0, 1'b0, "R3 page bits set");
    run_erase(17'h0_5A65, 8'hC1, 1'b0, 1'b0, "R7 status fail");
    run_erase(17'h0_0421, 8'hC0, 1'b0, 1'b1, "R9 start while busy");
    run_erase(17'h1_2345, 8'hC0, 1'b1, 1'b0, "R10 timeout");
    run_erase(17'h1FFFF, 8'hC0, 1'b0, 1'b0, "R4 max address after timeout");

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule